// File: doc/BRIEF.md
# Cipher Key Register Bank

This block stores the secret key used by a block cipher engine. Software loads the key one 64-bit word at a time through a word address with a write strobe. A two-bit size register says whether 16, 24 or 32 bytes of the bank hold live key material. All 256 stored bits are driven onto a flat key bus for the expansion and datapath logic, which sit outside this block. Byte 0 of the key is the lowest byte of word address 0.

The engine raises a busy input while a message is being processed. A key write that arrives during that window is refused, so the key in use cannot change under the engine, and a sticky context-error flag is set. A combinational read port returns any stored word, which lets software save the key when it switches context in decrypt mode. When the saved key is written back with the restore input high, the bank raises a flag that tells the engine the key is already prepared and key expansion can be skipped.

Top module: `cipher_key_bank`

## Requirements
- R1: After a synchronous active-low reset, all key words read zero, the size code is 0 (16 bytes), and ctx_err, size_err and skip_expand are low.
- R2: A key write to word address k, accepted on a clock edge, appears on key_bus bits [64k+63:64k] after that edge. Address 0 holds key bytes 0 to 7.
- R3: The size code selects the live key length: 0 = 16 bytes (addresses 0-1), 1 = 24 bytes (addresses 0-2), 2 = 32 bytes (addresses 0-3). Bytes of a key write that fall past the live length are dropped, and the stored key keeps its value.
- R4: Writing size code 3 leaves the size unchanged and sets size_err.
- R5: A reinit pulse clears every key word to zero and clears skip_expand. Reinit takes priority over a key write in the same cycle.
- R6: A key write while busy is high changes no stored byte and sets ctx_err on the following edge.
- R7: ctx_err and size_err stay set until err_clr or reset. If a new error and err_clr arrive in the same cycle, the error flag ends up set.
- R8: rd_data always shows the stored word selected by rd_addr, in the same cycle.
- R9: A key write that is accepted (busy low, at least one byte in range) sets skip_expand when restore_mode is high and clears it when restore_mode is low. A refused or fully dropped write leaves skip_expand unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_wr | input | 1 | Key word write strobe |
| key_addr | input | 2 | Key word address |
| key_wdata | input | 64 | Key word write data, byte 0 in bits [7:0] |
| size_wr | input | 1 | Size register write strobe |
| size_wdata | input | 2 | Size code to write |
| restore_mode | input | 1 | Marks key writes as a restore of a prepared decrypt key |
| reinit | input | 1 | Clears the key words |
| busy | input | 1 | Message processing is active |
| err_clr | input | 1 | Clears both error flags |
| rd_addr | input | 2 | Read-back word address |
| rd_data | output | 64 | Read-back word |
| key_bus | output | 256 | All stored key bytes to the engine |
| key_size | output | 2 | Current size code |
| ctx_err | output | 1 | Sticky flag: key written during processing |
| size_err | output | 1 | Sticky flag: illegal size code written |
| skip_expand | output | 1 | Stored key is a restored, prepared decrypt key |

## Verification
A wrong byte-enable or address decode shows up on key_bus and rd_data on the first edge after the faulty write. A write that is let through while busy, or while out of range, shows as a changed word on the next edge, and that error persists until the next reinit. Flag faults show the same way: a flag that clears itself when it should stay set, a size code that moves on an illegal write, or a restore flag that does not follow restore_mode. Each of these appears on the status outputs one cycle after the stimulus. The bench compares the complete output state after every operation, so each fault is caught at the first comparison that follows it.

// File: rtl/kb_pkg.sv
// Package: shared encodings and helpers for the cipher key bank.
// Assumes byte-granular key storage, sizes expressed as a two-bit code.
package kb_pkg;

    typedef enum logic [1:0] {
        KSZ_16  = 2'd0,
        KSZ_24  = 2'd1,
        KSZ_32  = 2'd2,
        KSZ_BAD = 2'd3
    } key_size_e;

    // Number of live key bytes for a legal size code.
    function automatic int live_bytes(input logic [1:0] code);
        case (code)
            2'd0:    live_bytes = 16;
            2'd1:    live_bytes = 24;
            2'd2:    live_bytes = 32;
            default: live_bytes = 16;
        endcase
    endfunction

endpackage

// File: rtl/kb_size_ctl.sv
// Module: holds the key size code and rejects the illegal code.
// Assumes size_wdata is sampled only when size_wr is high.
module kb_size_ctl
    import kb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       size_wr,
    input  logic [1:0] size_wdata,
    output logic [1:0] size_code,
    output logic       size_bad
);

    key_size_e size_q;

    // Illegal write detection, pulsed for one cycle.
    always_comb begin
        size_bad = size_wr && (key_size_e'(size_wdata) == KSZ_BAD);
    end

    // Size register: loads legal codes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= KSZ_16;
        end else if (size_wr && !size_bad) begin
            size_q <= key_size_e'(size_wdata);
        end
    end

    assign size_code = size_q;

    assert_size_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        size_code != 2'd3);

    assert_bad_keeps_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
        size_bad |=> $stable(size_code));

endmodule

// File: rtl/kb_write_gate.sv
// Module: turns a key word write into per-byte enables.
// A byte is enabled only if the word is addressed, the engine is idle,
// and the byte lies inside the live key length. Also reports refused writes.
module kb_write_gate
    import kb_pkg::*;
#(
    parameter int NUM_WORDS  = 4,
    parameter int WORD_BYTES = 8,
    localparam int ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int NBYTES    = NUM_WORDS * WORD_BYTES
) (
    input  logic              key_wr,
    input  logic [ADDR_W-1:0] key_addr,
    input  logic              busy,
    input  logic [1:0]        size_code,
    output logic [NBYTES-1:0] byte_we,
    output logic              accept,
    output logic              blocked
);

    int lim;

    // Byte enable mask from address, idle state and live length.
    always_comb begin
        lim = live_bytes(size_code);
        for (int w = 0; w < NUM_WORDS; w++) begin
            for (int b = 0; b < WORD_BYTES; b++) begin
                byte_we[w*WORD_BYTES + b] = key_wr && !busy
                                           && (key_addr == ADDR_W'(w))
                                           && ((w*WORD_BYTES + b) < lim);
            end
        end
    end

    // Accepted when any byte lands; refused when the engine is busy.
    always_comb begin
        accept  = |byte_we;
        blocked = key_wr && busy;
    end

endmodule

// File: rtl/kb_store.sv
// Module: byte-wide key storage, one register per byte.
// Assumes reinit has priority over any byte write.
module kb_store #(
    parameter int NUM_WORDS  = 4,
    parameter int WORD_BYTES = 8,
    localparam int WORD_W    = WORD_BYTES * 8,
    localparam int NBYTES    = NUM_WORDS * WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reinit,
    input  logic [NBYTES-1:0] byte_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [NBYTES*8-1:0] key_flat
);

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        logic [7:0] byte_q;

        // One key byte: cleared on reset or reinit, loaded when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n || reinit) begin
                byte_q <= 8'h00;
            end else if (byte_we[g]) begin
                byte_q <= wdata[(g % WORD_BYTES)*8 +: 8];
            end
        end

        assign key_flat[g*8 +: 8] = byte_q;
    end

    assert_reinit_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> (key_flat == '0));

endmodule

// File: rtl/kb_status.sv
// Module: sticky error flags and the restored-key indicator.
// Assumes blocked/size_bad/accept are single-cycle qualifiers from the gate.
module kb_status (
    input  logic clk,
    input  logic rst_n,
    input  logic blocked,
    input  logic size_bad,
    input  logic accept,
    input  logic restore_mode,
    input  logic reinit,
    input  logic err_clr,
    output logic ctx_err,
    output logic size_err,
    output logic skip_expand
);

    // Context error: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          ctx_err <= 1'b0;
        else if (blocked)    ctx_err <= 1'b1;
        else if (err_clr)    ctx_err <= 1'b0;
    end

    // Size error: same set-over-clear rule.
    always_ff @(posedge clk) begin
        if (!rst_n)          size_err <= 1'b0;
        else if (size_bad)   size_err <= 1'b1;
        else if (err_clr)    size_err <= 1'b0;
    end

    // Restored-key flag follows restore_mode on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n || reinit) skip_expand <= 1'b0;
        else if (accept)      skip_expand <= restore_mode;
    end

    assert_ctx_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_err && !err_clr) |=> ctx_err);

    assert_size_err_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        size_bad |=> size_err);

    assert_restore_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && restore_mode && !reinit) |=> skip_expand);

endmodule

// File: rtl/cipher_key_bank.sv
// Module: top of the cipher key bank. Ties together size control, write
// gating, byte storage and status, and drives the read-back mux.
// Assumes a single write port and a combinational read port.
module cipher_key_bank
    import kb_pkg::*;
#(
    parameter int NUM_WORDS  = 4,
    parameter int WORD_BYTES = 8,
    localparam int ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int WORD_W    = WORD_BYTES * 8,
    localparam int NBYTES    = NUM_WORDS * WORD_BYTES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                key_wr,
    input  logic [ADDR_W-1:0]   key_addr,
    input  logic [WORD_W-1:0]   key_wdata,
    input  logic                size_wr,
    input  logic [1:0]          size_wdata,
    input  logic                restore_mode,
    input  logic                reinit,
    input  logic                busy,
    input  logic                err_clr,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [WORD_W-1:0]   rd_data,
    output logic [NBYTES*8-1:0] key_bus,
    output logic [1:0]          key_size,
    output logic                ctx_err,
    output logic                size_err,
    output logic                skip_expand
);

    logic [1:0]        size_code;
    logic              size_bad;
    logic [NBYTES-1:0] byte_we;
    logic              accept;
    logic              blocked;

    kb_size_ctl u_size (
        .clk        (clk),
        .rst_n      (rst_n),
        .size_wr    (size_wr),
        .size_wdata (size_wdata),
        .size_code  (size_code),
        .size_bad   (size_bad)
    );

    kb_write_gate #(.NUM_WORDS(NUM_WORDS), .WORD_BYTES(WORD_BYTES)) u_gate (
        .key_wr    (key_wr),
        .key_addr  (key_addr),
        .busy      (busy),
        .size_code (size_code),
        .byte_we   (byte_we),
        .accept    (accept),
        .blocked   (blocked)
    );

    kb_store #(.NUM_WORDS(NUM_WORDS), .WORD_BYTES(WORD_BYTES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .reinit   (reinit),
        .byte_we  (byte_we),
        .wdata    (key_wdata),
        .key_flat (key_bus)
    );

    kb_status u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .blocked      (blocked),
        .size_bad     (size_bad),
        .accept       (accept),
        .restore_mode (restore_mode),
        .reinit       (reinit),
        .err_clr      (err_clr),
        .ctx_err      (ctx_err),
        .size_err     (size_err),
        .skip_expand  (skip_expand)
    );

    // Read-back mux over stored words.
    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (rd_addr == ADDR_W'(w)) rd_data = key_bus[w*WORD_W +: WORD_W];
        end
    end

    assign key_size = size_code;

    // Live word count for the current size, for the range check below.
    int live_words;
    always_comb live_words = live_bytes(key_size) / WORD_BYTES;

    assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && busy && !reinit) |=> $stable(key_bus));

    assert_busy_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && busy) |=> ctx_err);

    assert_out_of_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && !reinit && (int'(key_addr) >= live_words)) |=> $stable(key_bus));

endmodule

// File: tb/test_cipher_key_bank.sv
`timescale 1ns/1ps
module test_cipher_key_bank;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_wr = 1'b0;
    logic [1:0]   key_addr = '0;
    logic [63:0]  key_wdata = '0;
    logic         size_wr = 1'b0;
    logic [1:0]   size_wdata = '0;
    logic         restore_mode = 1'b0;
    logic         reinit = 1'b0;
    logic         busy = 1'b0;
    logic         err_clr = 1'b0;
    logic [1:0]   rd_addr = '0;
    logic [63:0]  rd_data;
    logic [255:0] key_bus;
    logic [1:0]   key_size;
    logic         ctx_err, size_err, skip_expand;

    cipher_key_bank i_cipher_key_bank (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_addr(key_addr),
        .key_wdata(key_wdata), .size_wr(size_wr), .size_wdata(size_wdata),
        .restore_mode(restore_mode), .reinit(reinit), .busy(busy),
        .err_clr(err_clr), .rd_addr(rd_addr), .rd_data(rd_data),
        .key_bus(key_bus), .key_size(key_size), .ctx_err(ctx_err),
        .size_err(size_err), .skip_expand(skip_expand)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        string        tag;
        logic [255:0] key;
        logic [63:0]  rd;
        logic [1:0]   size;
        logic         ctx, szerr, skip;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Reference model, kept from the requirements.
    logic [63:0] m_word [4];
    logic [1:0]  m_size = 2'd0;
    logic        m_ctx = 1'b0, m_szerr = 1'b0, m_skip = 1'b0;

    task automatic push_expect(input string tag);
        exp_t e;
        e.tag = tag;
        for (int w = 0; w < 4; w++) e.key[w*64 +: 64] = m_word[w];
        e.rd = m_word[rd_addr];
        e.size = m_size; e.ctx = m_ctx; e.szerr = m_szerr; e.skip = m_skip;
        q.push_back(e);
        wait (q.size() == 0);
    endtask

    task automatic idle_inputs();
        key_wr = 0; size_wr = 0; reinit = 0; err_clr = 0; busy = 0; restore_mode = 0;
    endtask

    task automatic key_write(input logic [1:0] a, input logic [63:0] d,
                             input logic rst_md, input logic bz, input logic clr,
                             input string tag);
        @(negedge clk);
        key_wr = 1; key_addr = a; key_wdata = d; restore_mode = rst_md;
        busy = bz; err_clr = clr;
        @(negedge clk);
        idle_inputs();
        if (bz) begin
            m_ctx = 1'b1;
        end else begin
            if (clr) m_ctx = 1'b0;
            if (int'(a) < 2 + int'(m_size)) begin
                m_word[a] = d;
                m_skip = rst_md;
            end
        end
        if (clr) m_szerr = 1'b0;
        push_expect(tag);
    endtask

    task automatic size_write(input logic [1:0] c, input string tag);
        @(negedge clk);
        size_wr = 1; size_wdata = c;
        @(negedge clk);
        idle_inputs();
        if (c == 2'd3) m_szerr = 1'b1; else m_size = c;
        push_expect(tag);
    endtask

    task automatic clear_errors(input string tag);
        @(negedge clk);
        err_clr = 1;
        @(negedge clk);
        idle_inputs();
        m_ctx = 0; m_szerr = 0;
        push_expect(tag);
    endtask

    task automatic do_reinit(input logic also_write, input string tag);
        @(negedge clk);
        reinit = 1;
        if (also_write) begin key_wr = 1; key_addr = 2'd0; key_wdata = 64'hFFFF_0000_FFFF_0000; restore_mode = 1; end
        @(negedge clk);
        idle_inputs();
        for (int w = 0; w < 4; w++) m_word[w] = '0;
        m_skip = 0;
        push_expect(tag);
    endtask

    // Monitor: pops one expected item per cycle and compares all outputs.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (key_bus !== e.key || rd_data !== e.rd || key_size !== e.size ||
                ctx_err !== e.ctx || size_err !== e.szerr || skip_expand !== e.skip) begin
                n_bad++;
                $display("FAIL %s: key=%h rd=%h size=%0d ctx=%b szerr=%b skip=%b | exp key=%h rd=%h size=%0d ctx=%b szerr=%b skip=%b",
                         e.tag, key_bus, rd_data, key_size, ctx_err, size_err, skip_expand,
                         e.key, e.rd, e.size, e.ctx, e.szerr, e.skip);
            end
        end
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 4; w++) m_word[w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        push_expect("R1 reset state");

        key_write(2'd0, 64'h0706_0504_0302_0100, 0, 0, 0, "R2 word0 low bytes");
        key_write(2'd1, 64'h0F0E_0D0C_0B0A_0908, 0, 0, 0, "R2 word1");
        rd_addr = 2'd1;
        push_expect("R8 read word1");
        key_write(2'd2, 64'hDEAD_BEEF_0000_1111, 0, 0, 0, "R3 drop past 16 bytes");
        key_write(2'd3, 64'hCAFE_CAFE_CAFE_CAFE, 0, 0, 0, "R3 drop word3 at 16 bytes");

        size_write(2'd2, "R3 size 32");
        key_write(2'd2, 64'h1716_1514_1312_1110, 0, 0, 0, "R2 word2 at 32");
        key_write(2'd3, 64'h1F1E_1D1C_1B1A_1918, 0, 0, 0, "R2 word3 at 32");
        size_write(2'd1, "R3 size 24");
        key_write(2'd3, 64'h5555_5555_5555_5555, 0, 0, 0, "R3 drop word3 at 24");
        key_write(2'd2, 64'h2726_2524_2322_2120, 0, 0, 0, "R3 word2 at 24");

        size_write(2'd3, "R4 illegal size");
        clear_errors("R7 clear size_err");

        key_write(2'd0, 64'hAAAA_AAAA_AAAA_AAAA, 0, 1, 0, "R6 busy write blocked");
        @(negedge clk);
        push_expect("R7 ctx_err holds");
        clear_errors("R7 ctx_err clears");
        key_write(2'd1, 64'hBBBB_BBBB_BBBB_BBBB, 0, 1, 1, "R7 set beats clear");
        clear_errors("R7 clear again");

        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            push_expect("R8 read sweep");
        end

        key_write(2'd0, 64'h1234_5678_9ABC_DEF0, 1, 0, 0, "R9 restore sets skip");
        key_write(2'd3, 64'h7777_7777_7777_7777, 0, 0, 0, "R9 dropped write keeps skip");
        key_write(2'd1, 64'h1111_2222_3333_4444, 1, 1, 0, "R9 busy restore ignored");
        key_write(2'd1, 64'h0F0E_0D0C_0B0A_0908, 0, 0, 0, "R9 plain write clears skip");
        key_write(2'd2, 64'h0000_0000_0000_00AA, 1, 0, 0, "R9 restore again");

        do_reinit(1'b1, "R5 reinit clears with write");
        rd_addr = 2'd2;
        push_expect("R5 read after reinit");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule